// File: doc/BRIEF.md
# Channel Pre-Indication Correlation Monitor

This block watches the channel handshake of a channelized transmit port. Ahead of each transfer, the core raises a request strobe together with a channel number. The client must then answer with a stream-valid strobe and the same channel number. That answer must come exactly `LATENCY` clocks later, where `LATENCY` is fixed when the block is built. The monitor keeps its own copy of every request in a shift line and compares the far end of that line against the live response on every clock. Any difference in the valid bit, or in the channel number while both are valid, raises a sticky correlation error. The error also freezes a record of what was expected and what was seen.

The monitor also polices the status path back toward the client. A status strobe is legal only while a skip request is asserted. For each channel, the number of status reports must never exceed the number of times the client has presented that channel. Each channel has a saturating credit counter. Every presentation of a channel adds one credit and every status report for that channel spends one. A report that finds no credit is an over-report.

The block only observes. It has no ready input and applies no back-pressure: every input is sampled on every rising clock edge, and the error outputs are plain sticky levels with one shared clear. Payload data is not examined.

Top module: `chan_corr_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, all error flags and captured fields read zero. The delay line starts empty, so no response is expected during the first `LATENCY` clocks.
- R2: A response is correct when `rsp_vld` equals the value `req_vld` had `LATENCY` clocks earlier. When the two valid bits differ, `err_corr` is high from the next clock on.
- R3: When both the delayed request and the response are valid but their channel numbers differ, `err_corr` is set. On the error that sets the flag from clear, `err_exp_vld`/`err_exp_id` capture the delayed request and `err_obs_vld`/`err_obs_id` capture the response. Later errors do not change these fields while the flag stays set.
- R4: A clock with `stat_vld`=1 and `stat_skip`=0 sets `err_noskip` and captures `stat_id` into `err_noskip_id`, but only when the flag was clear.
- R5: Each clock, `rsp_vld` adds one credit to channel `rsp_id`, and `stat_vld` takes one credit from channel `stat_id`, whatever `stat_skip` is. A report that finds zero credit sets `err_over` and captures its channel into `err_over_id` (only when the flag was clear). The credit then stays at zero.
- R6: If a presentation and a status report name the same channel in the same clock, that channel's credit does not change, and no over-report is raised even when the credit was zero.
- R7: All error flags are sticky. `err_clr`=1 drops every flag on the next clock, unless a new error of that kind arrives in the same clock. In that case the flag stays set and its captured fields take the new error.
- R8: A credit counter saturates at 2^`CNT_W`-1. Presentations beyond that count are lost. With `CNT_W`=8, 300 presentations of one channel allow 255 reports, and the 256th is an over-report.
- R9: `req_id` is ignored while `req_vld` is 0, and `rsp_id` is ignored while `rsp_vld` is 0. Differing channel numbers on invalid cycles raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Pre-indication request strobe from the core |
| req_id | input | CH_W | Channel number of the request |
| rsp_vld | input | 1 | Client stream-valid strobe |
| rsp_id | input | CH_W | Channel number presented by the client |
| stat_vld | input | 1 | Status report strobe toward the client |
| stat_skip | input | 1 | Skip request accompanying status |
| stat_id | input | CH_W | Channel number of the status report |
| err_clr | input | 1 | Clears all sticky error flags |
| err_corr | output | 1 | Sticky request/response correlation error |
| err_exp_vld | output | 1 | Captured delayed request valid |
| err_exp_id | output | CH_W | Captured delayed request channel |
| err_obs_vld | output | 1 | Captured response valid |
| err_obs_id | output | CH_W | Captured response channel |
| err_noskip | output | 1 | Sticky status-without-skip error |
| err_noskip_id | output | CH_W | Channel of the first status without skip |
| err_over | output | 1 | Sticky status over-report error |
| err_over_id | output | CH_W | Channel of the first over-report |

## Verification
The bench replays mirrored traffic with scattered channel numbers. It then perturbs that traffic three ways: a wrong channel, a missing response and an unsolicited response. A delay line that is one stage short or long, or that compares channel numbers on invalid cycles, would flag clean traffic. A capture that is not frozen would report the last error instead of the first. For the status path, the bench presents a channel and reports it in the same clock while that channel holds no credit. A monitor that handles the increment and the decrement in sequence would raise a false over-report there. The bench also fills one credit counter past its limit: a counter that wraps would refuse reports far too early, or allow one report too many. Finally, it asserts clear in the same clock as a fresh error, which shows whether the clear wrongly takes priority over the new error.

// File: rtl/corr_pkg.sv
package corr_pkg;

  typedef enum logic [1:0] {
    CR_HOLD = 2'd0,
    CR_UP   = 2'd1,
    CR_DOWN = 2'd2
  } cred_op_e;

  // Same-channel gain and spend in one clock cancel out.
  function automatic cred_op_e cred_op(input logic gain, input logic spend);
    if (gain && !spend)      return CR_UP;
    else if (spend && !gain) return CR_DOWN;
    else                     return CR_HOLD;
  endfunction

endpackage

// File: rtl/corr_delay_line.sv
module corr_delay_line #(
  parameter int LATENCY = 4,
  parameter int CH_W    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [CH_W-1:0] in_id,
  output logic            out_vld,
  output logic [CH_W-1:0] out_id
);

  for (genvar s = 0; s < LATENCY; s++) begin : g_st
    logic            v;
    logic [CH_W-1:0] id;
    logic            v_d;
    logic [CH_W-1:0] id_d;

    if (s == 0) begin : g_head
      assign v_d  = in_vld;
      assign id_d = in_id;
    end else begin : g_body
      assign v_d  = g_st[s-1].v;
      assign id_d = g_st[s-1].id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v  <= 1'b0;
        id <= '0;
      end else begin
        v  <= v_d;
        id <= id_d;
      end
    end
  end

  assign out_vld = g_st[LATENCY-1].v;
  assign out_id  = g_st[LATENCY-1].id;

endmodule

// File: rtl/corr_credit_bank.sv
module corr_credit_bank
  import corr_pkg::*;
#(
  parameter int CH_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pres_vld,
  input  logic [CH_W-1:0]        pres_id,
  input  logic                   rep_vld,
  input  logic [CH_W-1:0]        rep_id,
  output logic [(1<<CH_W)-1:0]   cred_zero,
  output logic                   over_hit
);

  localparam int              CH_N    = 1 << CH_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             gain;
    logic             spend;

    assign gain  = pres_vld && (pres_id == CH_W'(g));
    assign spend = rep_vld  && (rep_id  == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
      end else begin
        case (cred_op(gain, spend))
          CR_UP:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          CR_DOWN: if (cnt != '0)      cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign cred_zero[g] = (cnt == '0);
  end

  logic same_ch;
  assign same_ch  = pres_vld && (pres_id == rep_id);
  assign over_hit = rep_vld && cred_zero[rep_id] && !same_ch;

endmodule

// File: rtl/corr_err_trap.sv
module corr_err_trap #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         clr,
  input  logic [W-1:0] info,
  output logic         flag,
  output logic [W-1:0] held
);

  logic take;
  assign take = hit && (!flag || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      held <= '0;
    end else begin
      flag <= hit || (flag && !clr);
      if (take) held <= info;
    end
  end

endmodule

// File: rtl/chan_corr_monitor.sv
module chan_corr_monitor
  import corr_pkg::*;
#(
  parameter int LATENCY = 4,
  parameter int CH_W    = 6,
  parameter int CNT_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [CH_W-1:0] req_id,
  input  logic            rsp_vld,
  input  logic [CH_W-1:0] rsp_id,
  input  logic            stat_vld,
  input  logic            stat_skip,
  input  logic [CH_W-1:0] stat_id,
  input  logic            err_clr,
  output logic            err_corr,
  output logic            err_exp_vld,
  output logic [CH_W-1:0] err_exp_id,
  output logic            err_obs_vld,
  output logic [CH_W-1:0] err_obs_id,
  output logic            err_noskip,
  output logic [CH_W-1:0] err_noskip_id,
  output logic            err_over,
  output logic [CH_W-1:0] err_over_id
);

  localparam int CH_N  = 1 << CH_W;
  localparam int CAP_W = 2 * CH_W + 2;

  logic            dly_vld;
  logic [CH_W-1:0] dly_id;

  corr_delay_line #(.LATENCY(LATENCY), .CH_W(CH_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (req_vld),
    .in_id  (req_id),
    .out_vld(dly_vld),
    .out_id (dly_id)
  );

  logic vld_diff;
  logic id_diff;
  logic mismatch;
  assign vld_diff = (dly_vld != rsp_vld);
  assign id_diff  = dly_vld && rsp_vld && (dly_id != rsp_id);
  assign mismatch = vld_diff || id_diff;

  logic [CAP_W-1:0] corr_info;
  logic [CAP_W-1:0] corr_held;
  assign corr_info = {dly_vld, dly_id, rsp_vld, rsp_id};

  corr_err_trap #(.W(CAP_W)) u_trap_corr (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (mismatch),
    .clr  (err_clr),
    .info (corr_info),
    .flag (err_corr),
    .held (corr_held)
  );

  assign {err_exp_vld, err_exp_id, err_obs_vld, err_obs_id} = corr_held;

  logic noskip_hit;
  assign noskip_hit = stat_vld && !stat_skip;

  corr_err_trap #(.W(CH_W)) u_trap_noskip (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (noskip_hit),
    .clr  (err_clr),
    .info (stat_id),
    .flag (err_noskip),
    .held (err_noskip_id)
  );

  logic [CH_N-1:0] cred_zero;
  logic            over_hit;

  corr_credit_bank #(.CH_W(CH_W), .CNT_W(CNT_W)) u_cred (
    .clk      (clk),
    .rst_n    (rst_n),
    .pres_vld (rsp_vld),
    .pres_id  (rsp_id),
    .rep_vld  (stat_vld),
    .rep_id   (stat_id),
    .cred_zero(cred_zero),
    .over_hit (over_hit)
  );

  corr_err_trap #(.W(CH_W)) u_trap_over (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (over_hit),
    .clr  (err_clr),
    .info (stat_id),
    .flag (err_over),
    .held (err_over_id)
  );

endmodule

// File: rtl/corr_monitor_chk.sv
module corr_monitor_chk #(
  parameter int CH_W = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rsp_vld,
  input logic [CH_W-1:0]      rsp_id,
  input logic                 stat_vld,
  input logic                 stat_skip,
  input logic [CH_W-1:0]      stat_id,
  input logic                 err_clr,
  input logic                 dly_vld,
  input logic [CH_W-1:0]      dly_id,
  input logic [(1<<CH_W)-1:0] cred_zero,
  input logic                 err_corr,
  input logic                 err_exp_vld,
  input logic [CH_W-1:0]      err_exp_id,
  input logic                 err_obs_vld,
  input logic [CH_W-1:0]      err_obs_id,
  input logic                 err_noskip,
  input logic                 err_over
);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!err_corr && !err_noskip && !err_over); // R1
    end
  end

  AST_VLD_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_vld != rsp_vld) |=> err_corr); // R2

  AST_ID_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_vld && rsp_vld && dly_id != rsp_id) |=> err_corr); // R3

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (err_corr && !err_clr) |=> $stable({err_exp_vld, err_exp_id, err_obs_vld, err_obs_id})); // R3

  AST_NOSKIP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !stat_skip) |=> err_noskip); // R4

  AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && cred_zero[stat_id] && !(rsp_vld && rsp_id == stat_id)) |=> err_over); // R5

  AST_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && rsp_vld && rsp_id == stat_id && !err_over) |=> !err_over); // R6

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && dly_vld == rsp_vld && !(dly_vld && dly_id != rsp_id)) |=> !err_corr); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!dly_vld && !rsp_vld && !err_corr) |=> !err_corr); // R9

endmodule

bind chan_corr_monitor corr_monitor_chk #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rsp_vld    (rsp_vld),
  .rsp_id     (rsp_id),
  .stat_vld   (stat_vld),
  .stat_skip  (stat_skip),
  .stat_id    (stat_id),
  .err_clr    (err_clr),
  .dly_vld    (dly_vld),
  .dly_id     (dly_id),
  .cred_zero  (cred_zero),
  .err_corr   (err_corr),
  .err_exp_vld(err_exp_vld),
  .err_exp_id (err_exp_id),
  .err_obs_vld(err_obs_vld),
  .err_obs_id (err_obs_id),
  .err_noskip (err_noskip),
  .err_over   (err_over)
);

// File: tb/chan_corr_monitor_test.sv
module chan_corr_monitor_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LAT  = 4;
  localparam int CW   = 6;
  localparam int CN   = 1 << CW;
  localparam int CMAX = 255;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_vld = 1'b0, rsp_vld = 1'b0, stat_vld = 1'b0, stat_skip = 1'b0, err_clr = 1'b0;
  logic [CW-1:0] req_id = '0, rsp_id = '0, stat_id = '0;
  logic          err_corr, err_exp_vld, err_obs_vld, err_noskip, err_over;
  logic [CW-1:0] err_exp_id, err_obs_id, err_noskip_id, err_over_id;

  chan_corr_monitor #(.LATENCY(LAT), .CH_W(CW), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_id(req_id),
    .rsp_vld(rsp_vld), .rsp_id(rsp_id),
    .stat_vld(stat_vld), .stat_skip(stat_skip), .stat_id(stat_id),
    .err_clr(err_clr),
    .err_corr(err_corr), .err_exp_vld(err_exp_vld), .err_exp_id(err_exp_id),
    .err_obs_vld(err_obs_vld), .err_obs_id(err_obs_id),
    .err_noskip(err_noskip), .err_noskip_id(err_noskip_id),
    .err_over(err_over), .err_over_id(err_over_id)
  );

  typedef struct {
    int    corr, ev, eid, ov, oid, ns, nsid, ovr, ovrid;
    string tag;
  } exp_t;

  exp_t sbq[$];
  exp_t st;
  int   hv[LAT];
  int   hid[LAT];
  int   cred[CN];
  int   n_run = 0, n_fail = 0;

  task automatic chk(string req, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Driver: applies one clock of stimulus and pushes the expected outputs.
  task automatic step(input bit rv, input int rid, input bit mirror, input bit pv, input int pid,
                      input bit sv, input bit sk, input int sid, input bit clr, input string tag);
    int dv, did, mm;
    bit ovh;
    @(negedge clk);
    dv  = hv[LAT-1];
    did = hid[LAT-1];
    if (mirror) begin pv = (dv != 0); pid = did; end
    req_vld = rv; req_id = CW'(rid); rsp_vld = pv; rsp_id = CW'(pid);
    stat_vld = sv; stat_skip = sk; stat_id = CW'(sid); err_clr = clr;
    for (int i = LAT-1; i > 0; i--) begin hv[i] = hv[i-1]; hid[i] = hid[i-1]; end
    hv[0] = rv; hid[0] = rid;
    mm = ((dv != 0) != pv) || ((dv != 0) && pv && did != pid);
    if (mm && (st.corr == 0 || clr)) begin
      st.ev = dv; st.eid = (dv != 0 || 1) ? did : 0; st.ov = pv; st.oid = pid;
    end
    st.corr = (mm != 0) || (st.corr != 0 && !clr);
    if (sv && !sk && (st.ns == 0 || clr)) st.nsid = sid;
    st.ns = (sv && !sk) || (st.ns != 0 && !clr);
    ovh = sv && cred[sid] == 0 && !(pv && pid == sid);
    if (ovh && (st.ovr == 0 || clr)) st.ovrid = sid;
    st.ovr = ovh || (st.ovr != 0 && !clr);
    if (!(pv && sv && pid == sid)) begin
      if (pv && cred[pid] < CMAX) cred[pid]++;
      if (sv && cred[sid] > 0) cred[sid]--;
    end
    st.tag = tag;
    sbq.push_back(st);
  endtask

  // Monitor: compares one expected item per clock, after the edge settles.
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk({"R2 ", e.tag}, "err_corr", err_corr, e.corr);
      chk({"R3 ", e.tag}, "err_exp_vld", err_exp_vld, e.ev);
      chk({"R3 ", e.tag}, "err_exp_id", err_exp_id, e.eid);
      chk({"R3 ", e.tag}, "err_obs_vld", err_obs_vld, e.ov);
      chk({"R3 ", e.tag}, "err_obs_id", err_obs_id, e.oid);
      chk({"R4 ", e.tag}, "err_noskip", err_noskip, e.ns);
      chk({"R4 ", e.tag}, "err_noskip_id", err_noskip_id, e.nsid);
      chk({"R5 ", e.tag}, "err_over", err_over, e.ovr);
      chk({"R5 ", e.tag}, "err_over_id", err_over_id, e.ovrid);
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #750us;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    st = '{0, 0, 0, 0, 0, 0, 0, 0, 0, ""};
    for (int i = 0; i < LAT; i++) begin hv[i] = 0; hid[i] = 0; end
    for (int i = 0; i < CN; i++) cred[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "err_corr in reset", err_corr, 0);
    chk("R1", "err_noskip in reset", err_noskip, 0);
    chk("R1", "err_over in reset", err_over, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "err_corr after reset", err_corr, 0);
    chk("R1", "err_exp_id after reset", err_exp_id, 0);
    chk("R1", "err_over_id after reset", err_over_id, 0);

    // R9: channel numbers on invalid cycles are don't-care
    step(0, 17, 0, 0, 9, 0, 0, 0, 0, "R9 idle ids");
    step(0, 33, 0, 0, 44, 0, 0, 0, 0, "R9 idle ids");
    idle(LAT, "R9 drain");

    // R2: clean mirrored traffic, scattered channels 0..31
    for (int i = 0; i < 40; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 31), 1, 0, 0, 0, 0, 0, 0, "R2 mirror");
    idle(LAT, "R2 drain");

    // R3: wrong channel in the response, then a second wrong one that must not overwrite
    step(1, 12, 0, 0, 0, 0, 0, 0, 0, "R3 req");
    step(1, 7, 0, 0, 0, 0, 0, 0, 0, "R3 req");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 gap");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 gap");
    step(0, 0, 0, 1, 13, 0, 0, 0, 0, "R3 bad id");
    step(0, 0, 0, 1, 8, 0, 0, 0, 0, "R3 second bad id");
    idle(3, "R3 hold");

    // R7: clear drops the flag
    step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R7 clear");
    idle(2, "R7 after clear");

    // R2: missing response
    step(1, 21, 1, 0, 0, 0, 0, 0, 0, "R2 req");
    idle(LAT - 1, "R2 wait");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 missing rsp");
    idle(2, "R2 hold");
    step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R7 clear");

    // R2: unsolicited response, then R7 clear in the same clock as a new error
    step(0, 0, 0, 1, 30, 0, 0, 0, 0, "R2 extra rsp");
    step(0, 0, 0, 1, 31, 0, 0, 0, 1, "R7 clear vs new error");
    idle(2, "R7 kept");
    step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R7 clear");

    // R4: status without skip; with skip it is clean
    step(0, 0, 1, 0, 0, 1, 1, 30, 0, "R4 status with skip");
    step(0, 0, 1, 0, 0, 1, 0, 31, 0, "R4 status no skip");
    step(0, 0, 1, 0, 0, 1, 0, 5, 0, "R4 second no skip");
    idle(2, "R4 hold");
    step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R7 clear");

    // R5: over-report on channel 63, which has never been presented
    step(0, 0, 1, 0, 0, 1, 1, 63, 0, "R5 over report");
    step(0, 0, 1, 0, 0, 1, 1, 63, 0, "R5 repeat over");
    idle(2, "R5 hold");
    step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R7 clear");

    // R6: same-clock presentation and report on zero-credit channel 62
    step(1, 62, 1, 0, 0, 0, 0, 0, 0, "R6 req");
    idle(LAT - 1, "R6 wait");
    step(0, 0, 1, 0, 0, 1, 1, 62, 0, "R6 net zero");
    idle(1, "R6 check");
    step(0, 0, 1, 0, 0, 1, 1, 62, 0, "R6 credit still zero");
    idle(2, "R6 hold");
    step(0, 0, 1, 0, 0, 0, 0, 0, 1, "R7 clear");

    // R8: saturation of one credit counter (channel 40)
    for (int i = 0; i < 300; i++) step(1, 40, 1, 0, 0, 0, 0, 0, 0, "R8 fill");
    idle(LAT, "R8 drain");
    for (int i = 0; i < CMAX; i++) step(0, 0, 1, 0, 0, 1, 1, 40, 0, "R8 spend");
    idle(1, "R8 no over yet");
    step(0, 0, 1, 0, 0, 1, 1, 40, 0, "R8 one too many");
    idle(2, "R8 hold");

    repeat (3) @(posedge clk);
    #2;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule